// File: doc/BRIEF.md
# Effective Address Generator

This block forms the 16-bit address an instruction refers to, from three inputs: the instruction word, the program counter after it has been incremented, and the value of the base register. The logic is purely combinational. The opcode in the top four bits picks one of three ways to form the address. A PC-relative instruction adds a sign-extended 9-bit offset to the incremented PC. A base-relative instruction adds a sign-extended 6-bit offset to the base register. A register jump uses the base register unchanged. No mode takes an absolute address from the instruction.

The block also presents the base-register index taken from the instruction, so the register file can supply `base_val_i`. Beside the address it gives three flags: whether the address is meaningful at all, whether memory is accessed, and whether the word read there is a pointer to the real operand. The register file, the memory access and the indirection step are outside the block. The load-effective-address opcode produces an address with no memory access, so the caller writes that address to a register as the result.

Top module: `ea_gen`

## Requirements
- R1: For opcodes 0000, 0010, 0011, 1010, 1011 and 1110, `addr_o` equals `pc_inc_i` plus `instr_i[8:0]` sign-extended to 16 bits.
- R2: For opcodes 0110 and 0111, `addr_o` equals `base_val_i` plus `instr_i[5:0]` sign-extended to 16 bits.
- R3: For opcode 1100, `addr_o` equals `base_val_i` exactly.
- R4: `base_sel_o` always equals `instr_i[8:6]`.
- R5: `indirect_o` is 1 for opcodes 1010 and 1011 and 0 for every other opcode.
- R6: `mem_acc_o` is 1 for opcodes 0010, 0011, 0110, 0111, 1010 and 1011. It is 0 for every other opcode, including 1110, 1100 and 0000.
- R7: `addr_valid_o` is 1 for the nine opcodes named in R1 to R3. For the other seven opcodes it is 0, and `addr_o` is 0 in that case.
- R8: Every addition wraps modulo 2^16.
- R9: The offset extremes are handled by sign extension. A 9-bit field gives -256 to +255, and a 6-bit field gives -32 to +31.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| instr_i | input | 16 | Instruction word; opcode in bits 15:12 |
| pc_inc_i | input | 16 | Program counter after increment |
| base_val_i | input | 16 | Value of the register named by `base_sel_o` |
| base_sel_o | output | 3 | Base-register index from bits 8:6 |
| addr_o | output | 16 | Computed address, 0 when not valid |
| addr_valid_o | output | 1 | Opcode forms an address |
| mem_acc_o | output | 1 | Address is used for a memory access |
| indirect_o | output | 1 | Word at the address is a pointer |

## Verification
All sixteen opcodes are driven with the same offset field patterns, so any opcode decoded into the wrong mode shows up as a wrong address or a wrong flag. The field patterns are:
- the most negative and most positive values of the 9-bit field;
- the most negative and most positive values of the 6-bit field;
- a base index of 7.

Because the two offsets share their low bits, each pattern separates the 9-bit extension from the 6-bit one. PC and base values placed near 0x0000 and 0xFFFF show whether the sum wraps or saturates. Random instruction words follow, and distinct PC and base values show whether the right operand was chosen.

// File: rtl/ea_pkg.sv
package ea_pkg;
  localparam int unsigned OPC_W = 4;

  typedef enum logic [1:0] {
    MODE_NONE  = 2'd0,
    MODE_PCREL = 2'd1,
    MODE_BASE  = 2'd2,
    MODE_REG   = 2'd3
  } ea_mode_e;

  localparam logic [OPC_W-1:0] OP_BR  = 4'b0000;
  localparam logic [OPC_W-1:0] OP_LD  = 4'b0010;
  localparam logic [OPC_W-1:0] OP_ST  = 4'b0011;
  localparam logic [OPC_W-1:0] OP_LDR = 4'b0110;
  localparam logic [OPC_W-1:0] OP_STR = 4'b0111;
  localparam logic [OPC_W-1:0] OP_LDI = 4'b1010;
  localparam logic [OPC_W-1:0] OP_STI = 4'b1011;
  localparam logic [OPC_W-1:0] OP_JMP = 4'b1100;
  localparam logic [OPC_W-1:0] OP_LEA = 4'b1110;
endpackage

// File: rtl/ea_decode.sv
module ea_decode
  import ea_pkg::*;
(
  input  logic [OPC_W-1:0] opc_i,
  output ea_mode_e         mode_o,
  output logic             mem_acc_o,
  output logic             indirect_o
);
  always_comb begin
    mode_o     = MODE_NONE;
    mem_acc_o  = 1'b0;
    indirect_o = 1'b0;
    unique case (opc_i)
      OP_BR, OP_LEA:        mode_o = MODE_PCREL;
      OP_LD, OP_ST: begin
        mode_o    = MODE_PCREL;
        mem_acc_o = 1'b1;
      end
      OP_LDI, OP_STI: begin
        mode_o     = MODE_PCREL;
        mem_acc_o  = 1'b1;
        indirect_o = 1'b1;
      end
      OP_LDR, OP_STR: begin
        mode_o    = MODE_BASE;
        mem_acc_o = 1'b1;
      end
      OP_JMP:               mode_o = MODE_REG;
      default:              mode_o = MODE_NONE;
    endcase
  end
endmodule

// File: rtl/ea_sext.sv
module ea_sext #(
  parameter int unsigned IN_W  = 9,
  parameter int unsigned OUT_W = 16
) (
  input  logic [IN_W-1:0]  val_i,
  output logic [OUT_W-1:0] val_o
);
  generate
    if (IN_W >= OUT_W) begin : g_trunc
      assign val_o = val_i[OUT_W-1:0];
    end else begin : g_ext
      assign val_o = {{(OUT_W-IN_W){val_i[IN_W-1]}}, val_i};
    end
  endgenerate
endmodule

// File: rtl/ea_gen.sv
module ea_gen
  import ea_pkg::*;
#(
  parameter int unsigned DATA_W     = 16,
  parameter int unsigned PC_OFF_W   = 9,
  parameter int unsigned BASE_OFF_W = 6,
  parameter int unsigned REG_SEL_W  = 3
) (
  input  logic [DATA_W-1:0]    instr_i,
  input  logic [DATA_W-1:0]    pc_inc_i,
  input  logic [DATA_W-1:0]    base_val_i,
  output logic [REG_SEL_W-1:0] base_sel_o,
  output logic [DATA_W-1:0]    addr_o,
  output logic                 addr_valid_o,
  output logic                 mem_acc_o,
  output logic                 indirect_o
);
  localparam int unsigned OPC_LSB = DATA_W - OPC_W;
  localparam int unsigned SEL_LSB = BASE_OFF_W;

  ea_mode_e          mode;
  logic [DATA_W-1:0] pc_off, base_off;
  logic [DATA_W-1:0] opnd_a, opnd_b;

  ea_decode i_dec (
    .opc_i      (instr_i[DATA_W-1:OPC_LSB]),
    .mode_o     (mode),
    .mem_acc_o  (mem_acc_o),
    .indirect_o (indirect_o)
  );

  ea_sext #(.IN_W(PC_OFF_W), .OUT_W(DATA_W)) i_sext_pc (
    .val_i (instr_i[PC_OFF_W-1:0]),
    .val_o (pc_off)
  );

  ea_sext #(.IN_W(BASE_OFF_W), .OUT_W(DATA_W)) i_sext_base (
    .val_i (instr_i[BASE_OFF_W-1:0]),
    .val_o (base_off)
  );

  assign base_sel_o = instr_i[SEL_LSB +: REG_SEL_W];

  // one shared adder; operands steered by mode
  always_comb begin
    opnd_a = '0;
    opnd_b = '0;
    unique case (mode)
      MODE_PCREL: begin opnd_a = pc_inc_i;   opnd_b = pc_off;   end
      MODE_BASE:  begin opnd_a = base_val_i; opnd_b = base_off; end
      MODE_REG:   begin opnd_a = base_val_i; opnd_b = '0;       end
      default:    begin opnd_a = '0;         opnd_b = '0;       end
    endcase
  end

  assign addr_o       = opnd_a + opnd_b;  // wraps mod 2^DATA_W
  assign addr_valid_o = (mode != MODE_NONE);

  always_comb begin
    p_ind_mem_r5: assert (!indirect_o || mem_acc_o)
      else $error("indirect without memory access");
    p_mem_valid_r6: assert (!mem_acc_o || addr_valid_o)
      else $error("memory access without address");
    p_idle_zero_r7: assert (addr_valid_o || addr_o == '0)
      else $error("address nonzero while invalid");
    p_jump_base_r3: assert (mode != MODE_REG || addr_o == base_val_i)
      else $error("jump address differs from base");
  end
endmodule

// File: tb/test_ea_gen.sv
module test_ea_gen;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  typedef struct {
    logic [15:0] addr;
    logic        valid, mem, ind;
    logic [2:0]  sel;
    string       tag;
  } item_t;

  logic        clk = 1'b0;
  logic [15:0] instr, pc_inc, base_val;
  logic [2:0]  base_sel;
  logic [15:0] addr;
  logic        addr_valid, mem_acc, indirect;
  item_t       exp_q[$];
  int          total = 0;
  int          bad   = 0;
  bit          done  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ea_gen i_ea_gen (
    .instr_i      (instr),
    .pc_inc_i     (pc_inc),
    .base_val_i   (base_val),
    .base_sel_o   (base_sel),
    .addr_o       (addr),
    .addr_valid_o (addr_valid),
    .mem_acc_o    (mem_acc),
    .indirect_o   (indirect)
  );

  function automatic item_t model(input logic [15:0] ins, input logic [15:0] pc,
                                  input logic [15:0] bv);
    item_t it;
    logic [15:0] o9, o6;
    o9 = {{7{ins[8]}}, ins[8:0]};
    o6 = {{10{ins[5]}}, ins[5:0]};
    it.sel = ins[8:6];
    it.addr = 16'h0; it.valid = 0; it.mem = 0; it.ind = 0;
    case (ins[15:12])
      4'b0000, 4'b1110: begin it.addr = pc + o9; it.valid = 1; it.tag = "R1"; end
      4'b0010, 4'b0011: begin it.addr = pc + o9; it.valid = 1; it.mem = 1; it.tag = "R1"; end
      4'b1010, 4'b1011: begin it.addr = pc + o9; it.valid = 1; it.mem = 1; it.ind = 1; it.tag = "R1/R5"; end
      4'b0110, 4'b0111: begin it.addr = bv + o6; it.valid = 1; it.mem = 1; it.tag = "R2"; end
      4'b1100:          begin it.addr = bv; it.valid = 1; it.tag = "R3"; end
      default:          it.tag = "R7";
    endcase
    return it;
  endfunction

  task automatic drive(input logic [15:0] ins, input logic [15:0] pc,
                       input logic [15:0] bv, input string note);
    item_t it;
    @(posedge clk);
    #1;
    instr = ins; pc_inc = pc; base_val = bv;
    it = model(ins, pc, bv);
    it.tag = {it.tag, " ", note};
    exp_q.push_back(it);
  endtask

  task automatic cmp(input string what, input string tag,
                     input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: instr=%h actual=%h expected=%h", tag, what, instr, act, exp);
    end
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (exp_q.size() != 0) begin
      item_t it;
      it = exp_q.pop_front();
      cmp("addr",  it.tag, addr, it.addr);
      cmp("valid", {it.tag, " R7"}, {15'd0, addr_valid}, {15'd0, it.valid});
      cmp("mem",   {it.tag, " R6"}, {15'd0, mem_acc}, {15'd0, it.mem});
      cmp("ind",   {it.tag, " R5"}, {15'd0, indirect}, {15'd0, it.ind});
      cmp("sel",   "R4", {13'd0, base_sel}, {13'd0, it.sel});
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    for (int c = 0; c < WATCHDOG; c++) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    logic [11:0] fields [5];
    fields[0] = 12'h100;  // R9 pc off -256, base off 0
    fields[1] = 12'h0FF;  // R9 pc off +255, base off -1
    fields[2] = 12'h020;  // R9 base off -32
    fields[3] = 12'h01F;  // R9 base off +31
    fields[4] = 12'h1C0;  // R4 sel 7
    instr = 16'h1000; pc_inc = 16'h0000; base_val = 16'h0000;
    // idle state: non-addressing opcode gives zero outputs (R7)
    drive(16'h1000, 16'h1234, 16'h5678, "idle");
    for (int op = 0; op < 16; op++) begin
      for (int f = 0; f < 5; f++) begin
        drive({op[3:0], fields[f]}, 16'h3000, 16'h4000, "R9 extremes");
        // R8 wrap near both ends
        drive({op[3:0], fields[f]}, 16'hFFFF, 16'hFFF0, "R8 wrap high");
        drive({op[3:0], fields[f]}, 16'h0000, 16'h0010, "R8 wrap low");
      end
    end
    for (int k = 0; k < 200; k++)
      drive($urandom() & 16'hFFFF, $urandom() & 16'hFFFF, $urandom() & 16'hFFFF, "random");
    repeat (3) @(posedge clk);
    finish_run();
  end
endmodule